// File: doc/BRIEF.md
# Single-Transfer Matrix Multiply Engine

This block multiplies two signed 32-bit integer matrices, producing C = A x B. A has M rows and K columns, B has K rows and N columns, and the product C has M rows and N columns. All three shapes are fixed when the block is built. The caller presents both operand matrices as flat buses and raises `in_valid`. When the engine is idle it accepts them in a single ready/valid handshake and copies them into internal registers. It then frees the input buses and computes on its own.

The product is built one output row at a time, left to right. Within a row, a group of P adjacent columns is accumulated side by side by P multiply-accumulate lanes. Each lane adds one partial product per cycle, running over the shared index from 0 to K-1, and then writes its finished element into the result register. All arithmetic wraps modulo 2^32.

While the engine is computing, both `in_ready` and `out_valid` are low. When the final element has been written, both rise together. The finished matrix then stays on `c_flat` until the next job is accepted.

Top module: `mm_engine`

## Requirements
- R1: After synchronous reset, `in_ready` and `out_valid` are high and `c_flat` is all zero.
- R2: A job is accepted only on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low in the cycle that follows acceptance.
- R3: While a job is running, `in_ready` and `out_valid` are low. Any `in_valid`, `a_flat` or `b_flat` activity during that time has no effect on the result.
- R4: Each result element C[r][c] equals the sum over i of A[r][i]*B[i][c], truncated to 32 bits with two's-complement wraparound. No saturation is applied.
- R5: Exactly M*K*N/P clock cycles pass between the accepting edge and the edge after which `in_ready` is high again.
- R6: On completion, `in_ready` and `out_valid` rise in the same cycle. `c_flat` then holds the most recent product unchanged for as long as the block stays idle.
- R7: Element (r,c) of A sits at bits [(r*K+c)*32 +: 32] of `a_flat`. Element (r,c) of B sits at bits [(r*N+c)*32 +: 32] of `b_flat`. Element (r,c) of C sits at bits [(r*N+c)*32 +: 32] of `c_flat`. All three are row-major.
- R8: While idle with `in_valid` low, changes on `a_flat` and `b_flat` leave `c_flat` and `in_ready` unchanged.
- R9: A job accepted in the first cycle after a completion replaces the previous result entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Caller offers a pair of operand matrices |
| in_ready | output | 1 | Engine idle and able to accept a job |
| a_flat | input | M*K*32 | Matrix A, row-major, signed elements |
| b_flat | input | K*N*32 | Matrix B, row-major, signed elements |
| out_valid | output | 1 | `c_flat` holds the latest finished product |
| c_flat | output | M*N*32 | Product matrix C, row-major, signed elements |

## Verification
A counter that steps wrongly among row, column group and inner index shows up in two ways. Either the element at a specific (r,c) position of `c_flat` is wrong, or the number of busy cycles no longer equals M*K*N/P. Both are seen at the first completion after the fault. An accumulator that fails to clear between elements corrupts every element after the first one of the job, so random operands expose it in the first result read. A sequencer that stays busy or ends early changes the measured latency within a single job. An operand register that tracks the input bus during a job is caught because junk data is driven in every busy window.

// File: rtl/mm_pkg.sv
package mm_pkg;

    localparam int unsigned ELEM_W = 32;

    typedef logic signed [ELEM_W-1:0] elem_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } mm_state_e;

    // Loop position of the sequencer, shared with the datapath
    typedef struct packed {
        logic k_last;    // final inner-index step of the current elements
        logic job_last;  // final step of the whole job
    } step_flags_t;

    // Counter width, at least one bit
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Wrapping multiply-accumulate
    function automatic elem_t mac(input elem_t acc, input elem_t a, input elem_t b);
        logic signed [2*ELEM_W-1:0] prod;
        prod = a * b;
        return acc + elem_t'(prod[ELEM_W-1:0]);
    endfunction

endpackage

// File: rtl/mm_seq.sv
module mm_seq
    import mm_pkg::*;
#(
    parameter int unsigned ROWS   = 2,
    parameter int unsigned INNER  = 3,
    parameter int unsigned GROUPS = 2,
    localparam int unsigned RW = cnt_w(ROWS),
    localparam int unsigned KW = cnt_w(INNER),
    localparam int unsigned GW = cnt_w(GROUPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic [RW-1:0] row,
    output logic [GW-1:0] grp,
    output logic [KW-1:0] kk,
    output step_flags_t   flags
);
    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
    localparam logic [KW-1:0] K_MAX   = KW'(INNER - 1);
    localparam logic [GW-1:0] GRP_MAX = GW'(GROUPS - 1);

    mm_state_e state;

    assign busy           = (state == ST_BUSY);
    assign flags.k_last   = busy && (kk == K_MAX);
    assign flags.job_last = flags.k_last && (grp == GRP_MAX) && (row == ROW_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            row   <= '0;
            grp   <= '0;
            kk    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_BUSY;
                        row   <= '0;
                        grp   <= '0;
                        kk    <= '0;
                    end
                end
                ST_BUSY: begin
                    if (kk == K_MAX) begin
                        kk <= '0;
                        if (grp == GRP_MAX) begin
                            grp <= '0;
                            if (row == ROW_MAX) begin
                                row   <= '0;
                                state <= ST_IDLE;
                            end else begin
                                row <= row + 1'b1;
                            end
                        end else begin
                            grp <= grp + 1'b1;
                        end
                    end else begin
                        kk <= kk + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: loop indices stay inside the matrix bounds
    a_r5_index_bounds: assert property (@(posedge clk) disable iff (rst)
        busy |-> (kk <= K_MAX && grp <= GRP_MAX && row <= ROW_MAX));

    // R2: an accepted start always enters the busy phase at the first step
    a_r2_start_enters_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && kk == '0 && grp == '0 && row == '0));

    // R5: inner index advances by one per busy cycle until its last step
    a_r5_inner_steps: assert property (@(posedge clk) disable iff (rst)
        (busy && !flags.k_last) |=> (kk == $past(kk) + 1'b1));

endmodule

// File: rtl/mm_lane.sv
module mm_lane
    import mm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  en,
    input  logic  flush,
    input  elem_t a_in,
    input  elem_t b_in,
    output elem_t sum
);
    elem_t acc;

    assign sum = mac(acc, a_in, b_in);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= flush ? elem_t'(0) : sum;
        end
    end

    // R4: each element starts accumulating from zero
    a_r4_acc_cleared: assert property (@(posedge clk) disable iff (rst)
        (en && flush) |=> (acc == '0));

endmodule

// File: rtl/mm_engine.sv
module mm_engine
    import mm_pkg::*;
#(
    parameter int unsigned M = 2,
    parameter int unsigned K = 3,
    parameter int unsigned N = 4,
    parameter int unsigned P = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [M*K*ELEM_W-1:0] a_flat,
    input  logic [K*N*ELEM_W-1:0] b_flat,
    output logic                  out_valid,
    output logic [M*N*ELEM_W-1:0] c_flat
);
    localparam int unsigned NG  = N / P;
    localparam int unsigned RW  = cnt_w(M);
    localparam int unsigned KW  = cnt_w(K);
    localparam int unsigned GW  = cnt_w(NG);
    localparam int unsigned AIW = cnt_w(M * K);
    localparam int unsigned BIW = cnt_w(K * N);
    localparam int unsigned CIW = cnt_w(M * N);

    elem_t a_q [M*K];
    elem_t b_q [K*N];
    elem_t c_q [M*N];

    logic          busy;
    logic          start;
    logic [RW-1:0] row;
    logic [GW-1:0] grp;
    logic [KW-1:0] kk;
    step_flags_t   flags;

    elem_t a_sel;
    elem_t b_sel    [P];
    elem_t lane_sum [P];

    assign start     = in_valid && !busy;
    assign in_ready  = !busy;
    assign out_valid = !busy;

    mm_seq #(.ROWS(M), .INNER(K), .GROUPS(NG)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .row   (row),
        .grp   (grp),
        .kk    (kk),
        .flags (flags)
    );

    // Operand capture on acceptance
    always_ff @(posedge clk) begin
        if (start) begin
            for (int i = 0; i < M*K; i++) a_q[i] <= a_flat[i*ELEM_W +: ELEM_W];
            for (int i = 0; i < K*N; i++) b_q[i] <= b_flat[i*ELEM_W +: ELEM_W];
        end
    end

    // Shared A element of the current row, one B element per lane
    always_comb begin
        a_sel = a_q[AIW'(32'(row) * K + 32'(kk))];
        for (int l = 0; l < P; l++) begin
            b_sel[l] = b_q[BIW'(32'(kk) * N + 32'(grp) * P + l)];
        end
    end

    for (genvar l = 0; l < P; l++) begin : g_lane
        mm_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .clr   (start),
            .en    (busy),
            .flush (flags.k_last),
            .a_in  (a_sel),
            .b_in  (b_sel[l]),
            .sum   (lane_sum[l])
        );
    end

    // Result write-back when an element group finishes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < M*N; i++) c_q[i] <= '0;
        end else if (flags.k_last) begin
            for (int l = 0; l < P; l++) begin
                c_q[CIW'(32'(row) * N + 32'(grp) * P + l)] <= lane_sum[l];
            end
        end
    end

    for (genvar i = 0; i < M*N; i++) begin : g_out
        assign c_flat[i*ELEM_W +: ELEM_W] = c_q[i];
    end

    // R2: acceptance closes the input port on the next cycle
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R6: finishing the last step reopens the port with a valid result
    a_r6_finish_flags: assert property (@(posedge clk) disable iff (rst)
        (busy && flags.job_last) |=> (in_ready && out_valid));

    // R6: an idle engine keeps its result steady
    a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(c_flat));

    // R8: without a request the engine remains idle
    a_r8_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

endmodule

// File: tb/tb_mm_engine.sv
module tb_mm_engine;
    localparam int M   = 2;
    localparam int K   = 3;
    localparam int N   = 4;
    localparam int P   = 2;
    localparam int W   = 32;
    localparam int LAT = M * K * N / P;
    localparam int AW  = M * K * W;
    localparam int BW  = K * N * W;
    localparam int CW  = M * N * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] a_flat = '0;
    logic [BW-1:0] b_flat = '0;
    logic          out_valid;
    logic [CW-1:0] c_flat;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    mm_engine #(.M(M), .K(K), .N(N), .P(P)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .a_flat    (a_flat),
        .b_flat    (b_flat),
        .out_valid (out_valid),
        .c_flat    (c_flat)
    );

    // Reference product, row-major layout per R7, wrapping per R4
    function automatic logic [CW-1:0] ref_mul(input logic [AW-1:0] a, input logic [BW-1:0] b);
        logic [CW-1:0] c;
        c = '0;
        for (int r = 0; r < M; r++) begin
            for (int col = 0; col < N; col++) begin
                logic signed [W-1:0] s;
                s = '0;
                for (int i = 0; i < K; i++) begin
                    logic signed [W-1:0] x;
                    logic signed [W-1:0] y;
                    logic signed [2*W-1:0] pr;
                    x  = a[(r*K+i)*W +: W];
                    y  = b[(i*N+col)*W +: W];
                    pr = x * y;
                    s  = s + pr[W-1:0];
                end
                c[(r*N+col)*W +: W] = s;
            end
        end
        return c;
    endfunction

    function automatic logic [AW-1:0] rand_a();
        logic [AW-1:0] v;
        for (int i = 0; i < M*K; i++) v[i*W +: W] = $urandom;
        return v;
    endfunction

    function automatic logic [BW-1:0] rand_b();
        logic [BW-1:0] v;
        for (int i = 0; i < K*N; i++) v[i*W +: W] = $urandom;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one job; junk is driven on the inputs throughout the busy window (R3)
    task automatic run_job(input logic [AW-1:0] a, input logic [BW-1:0] b);
        int cnt;
        bit busy_ok;
        logic [CW-1:0] exp;
        exp = ref_mul(a, b);
        in_valid = 1'b1;
        a_flat = a;
        b_flat = b;
        @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b0, "R2 ready low after accept", CW'(in_ready), CW'(0));
        cnt = 0;
        busy_ok = 1'b1;
        while (!in_ready && cnt < 4 * LAT) begin
            if (out_valid) busy_ok = 1'b0;
            in_valid = 1'b1;
            a_flat = rand_a();
            b_flat = rand_b();
            @(negedge clk);
            cnt++;
        end
        in_valid = 1'b0;
        check(busy_ok, "R3 out_valid low while busy", CW'(!busy_ok), CW'(0));
        check(cnt == LAT, "R5 latency", CW'(cnt), CW'(LAT));
        check(in_ready && out_valid, "R6 ready and valid together", CW'({in_ready, out_valid}), CW'(3));
        check(c_flat == exp, "R4 R7 product value (R3 junk ignored)", c_flat, exp);
    endtask

    initial begin
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        logic [CW-1:0] held;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 in_ready after reset", CW'(in_ready), CW'(1));
        check(out_valid == 1'b1, "R1 out_valid after reset", CW'(out_valid), CW'(1));
        check(c_flat == '0, "R1 result zero after reset", c_flat, '0);

        // Directed: small known values
        for (int i = 0; i < M*K; i++) a[i*W +: W] = i + 1;
        for (int i = 0; i < K*N; i++) b[i*W +: W] = i - 5;
        run_job(a, b);

        // R8: idle input activity without valid changes nothing
        held = c_flat;
        for (int i = 0; i < 6; i++) begin
            a_flat = rand_a();
            b_flat = rand_b();
            @(negedge clk);
        end
        check(c_flat == held, "R8 idle inputs ignored", c_flat, held);
        check(in_ready == 1'b1, "R8 still ready", CW'(in_ready), CW'(1));

        // Directed R4 wraparound: most negative and most positive values
        for (int i = 0; i < M*K; i++) a[i*W +: W] = 32'h8000_0000;
        for (int i = 0; i < K*N; i++) b[i*W +: W] = (i % 2 == 0) ? 32'h8000_0000 : 32'h7fff_ffff;
        run_job(a, b);
        for (int i = 0; i < M*K; i++) a[i*W +: W] = 32'h7fff_ffff;
        for (int i = 0; i < K*N; i++) b[i*W +: W] = 32'hffff_ffff;
        run_job(a, b);

        // Directed: zero operand
        run_job('0, rand_b());

        // R9: back-to-back random jobs, each accepted right after the previous one
        for (int j = 0; j < 6; j++) begin
            run_job(rand_a(), rand_b());
        end

        // R6: result held while idle
        held = c_flat;
        repeat (5) @(negedge clk);
        check(c_flat == held && out_valid, "R6 result held while idle", c_flat, held);

        // R9: next job fully replaces prior result
        a = rand_a();
        b = rand_b();
        run_job(a, b);
        check(c_flat == ref_mul(a, b), "R9 result replaced", c_flat, ref_mul(a, b));

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule